// File: doc/BRIEF.md
# Expected Response Evaluation Controller

After a frame has been sent, this block decides whether the response seen on the receive side is the one that was expected. A descriptor is written in over a valid/ready handshake. It carries the kind of response awaited, the follow-up mode, a flag asking for a second info event, the 48-bit transmitter address, and a flag that widens address matching. The block watches the receive-side indications. These are a frame arrival with its class and receiver address, a response-info event, a second response-info event, and a "follow-up needed" hint. When the exchange ends, the block emits one status pulse carrying a 2-bit result code and a follow-up code.

The first frame that arrives during the wait window decides the result. A programmable window ends the wait if no frame arrives. Descriptor back-pressure follows these rules:
- `desc_ready` is high only while the block is idle.
- A descriptor is taken on a clock edge where `desc_valid` and `desc_ready` are both high.
- A producer must hold its descriptor until that edge.

Top module: `resp_eval_ctrl`

## Requirements
- R1: A descriptor is accepted only on an edge where `desc_valid` and `desc_ready` are both high. `desc_ready` is low from the edge after acceptance until the status pulse has been issued.
- R2: A descriptor with response type 0 starts no evaluation. `desc_ready` stays high, and no status pulse follows, even if receive events arrive.
- R3: Frame classes are encoded as ACK=0, BA=1, CTS=2, DATA=3, OTHER=4. Type 1 accepts only ACK, type 6 only CTS, and type 4 only OTHER. A frame of any other class gives result 01 (wrong type).
- R4: Types 2, 3, 21 and 22 accept any BA-class frame as success, whatever the bitmap size the type names.
- R5: Type 5 accepts ACK or BA. Type 7 accepts ACK or DATA. Any other class gives 01.
- R6: Type 17 accepts any class but checks the address. Type 18 and every unlisted code (8–16, 19, 20, 23–31) accept any class from any address.
- R7: Where the address is checked, the receiver address must equal the stored transmitter address. When the BSSID-check flag is 1, a match with `cfg_tbssid` is also accepted. A mismatch gives result 11 and takes priority over 01.
- R8: With the part-2 flag at 1, the status pulse follows the edge where `rx_info2_evt` is sampled after the first info event. A part-2 event seen before the first info event is ignored. With the flag at 0, the pulse follows the edge where the first info event is sampled.
- R9: If no frame is sampled within `cfg_sifs_limit` cycles after acceptance, the status pulse comes on the `cfg_sifs_limit`-th edge after acceptance with result 10 (timeout).
- R10: Follow-up modes are 0 none, 1 single-user BA, 2 multi-user BA and 3 command-driven. On success, `status_followup` equals the mode if `rx_resp_needed` was seen during the exchange, and 0 otherwise. In mode 3 it is always 0. On any failure it is 0.
- R11: `status_end` is high for exactly one cycle per exchange. `status_code` (00 success, 01 wrong type, 10 timeout, 11 address mismatch) and `status_followup` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Block idle and able to take a descriptor |
| desc_rtype | input | 5 | Expected response type |
| desc_r2r | input | 2 | Follow-up (response-to-response) mode |
| desc_part2 | input | 1 | Wait for second info event |
| desc_bss_chk | input | 1 | Also accept transmitted-BSSID match |
| desc_tx_addr | input | 48 | Transmitter address of the sent frame |
| cfg_tbssid | input | 48 | Transmitted-BSSID value |
| cfg_sifs_limit | input | 8 | Wait window in cycles, at least 1 |
| rx_frame_valid | input | 1 | A received frame is reported this cycle |
| rx_class | input | 3 | Class of the received frame |
| rx_ra | input | 48 | Receiver address of the received frame |
| rx_info_evt | input | 1 | First response-info event |
| rx_info2_evt | input | 1 | Second response-info event |
| rx_resp_needed | input | 1 | Receive side asks for a follow-up response |
| status_end | output | 1 | One-cycle end-of-exchange pulse |
| status_code | output | 2 | Result code |
| status_followup | output | 2 | Follow-up the transmit side may send |

## Verification
The assertions assume that `cfg_sifs_limit` is nonzero and does not change during a wait. They also assume the receive-side indications are single-cycle pulses, and that a frame is followed by its info events rather than arriving together with them. The stimulus drives every indication for one cycle at the falling edge and sets the configuration before each descriptor. It also spaces the frame, info and part-2 events at least one cycle apart, except in the ordering case, where a part-2 event is deliberately sent early.

// File: rtl/resp_eval_pkg.sv
package resp_eval_pkg;
  localparam int TYPE_W = 5;
  localparam int CLS_W  = 3;

  localparam logic [CLS_W-1:0] CLS_ACK   = 3'd0;
  localparam logic [CLS_W-1:0] CLS_BA    = 3'd1;
  localparam logic [CLS_W-1:0] CLS_CTS   = 3'd2;
  localparam logic [CLS_W-1:0] CLS_DATA  = 3'd3;
  localparam logic [CLS_W-1:0] CLS_OTHER = 3'd4;

  localparam logic [1:0] RES_OK      = 2'b00;
  localparam logic [1:0] RES_WRONG   = 2'b01;
  localparam logic [1:0] RES_TIMEOUT = 2'b10;
  localparam logic [1:0] RES_ADDR    = 2'b11;

  localparam logic [1:0] FU_CMD = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_FRAME,
    ST_WAIT_INFO,
    ST_WAIT_INFO2
  } state_e;
endpackage

// File: rtl/resp_type_judge.sv
module resp_type_judge
  import resp_eval_pkg::*;
(
  input  logic [TYPE_W-1:0] rtype,
  input  logic [CLS_W-1:0]  rx_class,
  output logic              class_ok,
  output logic              addr_needed
);
  always_comb begin
    class_ok    = 1'b1;
    addr_needed = 1'b0;
    case (rtype)
      5'd1:  begin class_ok = (rx_class == CLS_ACK);   addr_needed = 1'b1; end
      5'd2, 5'd3, 5'd21, 5'd22:
             begin class_ok = (rx_class == CLS_BA);    addr_needed = 1'b1; end
      5'd4:  begin class_ok = (rx_class == CLS_OTHER); addr_needed = 1'b1; end
      5'd5:  begin class_ok = (rx_class == CLS_ACK) || (rx_class == CLS_BA);   addr_needed = 1'b1; end
      5'd6:  begin class_ok = (rx_class == CLS_CTS);   addr_needed = 1'b1; end
      5'd7:  begin class_ok = (rx_class == CLS_ACK) || (rx_class == CLS_DATA); addr_needed = 1'b1; end
      5'd17: begin class_ok = 1'b1;                    addr_needed = 1'b1; end
      default: begin class_ok = 1'b1;                  addr_needed = 1'b0; end
    endcase
  end
endmodule

// File: rtl/resp_addr_match.sv
module resp_addr_match #(
  parameter int ADDR_W = 48,
  parameter bit BSS_EN = 1'b1
) (
  input  logic [ADDR_W-1:0] ra,
  input  logic [ADDR_W-1:0] tx_addr,
  input  logic [ADDR_W-1:0] tbssid,
  input  logic              bss_chk,
  output logic              hit
);
  logic tx_hit;
  logic bss_hit;

  assign tx_hit = (ra == tx_addr);

  generate
    if (BSS_EN) begin : g_bss
      assign bss_hit = bss_chk && (ra == tbssid);
    end else begin : g_no_bss
      logic unused_bss;
      assign unused_bss = bss_chk ^ (^tbssid);
      assign bss_hit = 1'b0;
    end
  endgenerate

  assign hit = tx_hit || bss_hit;
endmodule

// File: rtl/resp_eval_fsm.sv
module resp_eval_fsm
  import resp_eval_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [TYPE_W-1:0] desc_rtype,
  input  logic [1:0]        desc_r2r,
  input  logic              desc_part2,
  input  logic              desc_bss_chk,
  input  logic [ADDR_W-1:0] desc_tx_addr,
  input  logic [CNT_W-1:0]  cfg_limit,
  input  logic              rx_frame_valid,
  input  logic              frame_class_ok,
  input  logic              frame_addr_hit,
  input  logic              frame_addr_needed,
  input  logic              rx_info_evt,
  input  logic              rx_info2_evt,
  input  logic              rx_resp_needed,
  output logic [TYPE_W-1:0] rtype_q,
  output logic              bss_chk_q,
  output logic [ADDR_W-1:0] tx_addr_q,
  output logic              status_end,
  output logic [1:0]        status_code,
  output logic [1:0]        status_followup
);
  state_e           state;
  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       r2r_q;
  logic             part2_q;
  logic             needed_q;
  logic [1:0]       res_q;
  logic             needed_now;

  assign desc_ready = (state == ST_IDLE);
  assign needed_now = needed_q || rx_resp_needed;

  function automatic logic [1:0] followup_of(input logic [1:0] res,
                                             input logic [1:0] mode,
                                             input logic       asked);
    if (res != RES_OK || mode == FU_CMD || !asked) return 2'd0;
    return mode;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state           <= ST_IDLE;
      cnt_q           <= '0;
      r2r_q           <= '0;
      part2_q         <= 1'b0;
      needed_q        <= 1'b0;
      res_q           <= RES_OK;
      rtype_q         <= '0;
      bss_chk_q       <= 1'b0;
      tx_addr_q       <= '0;
      status_end      <= 1'b0;
      status_code     <= RES_OK;
      status_followup <= 2'd0;
    end else begin
      status_end <= 1'b0;
      if (state != ST_IDLE && rx_resp_needed) needed_q <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (desc_valid) begin
            rtype_q   <= desc_rtype;
            r2r_q     <= desc_r2r;
            part2_q   <= desc_part2;
            bss_chk_q <= desc_bss_chk;
            tx_addr_q <= desc_tx_addr;
            needed_q  <= 1'b0;
            cnt_q     <= '0;
            if (desc_rtype != '0) state <= ST_WAIT_FRAME;
          end
        end
        ST_WAIT_FRAME: begin
          if (rx_frame_valid) begin
            if (frame_addr_needed && !frame_addr_hit) res_q <= RES_ADDR;
            else if (!frame_class_ok)                 res_q <= RES_WRONG;
            else                                      res_q <= RES_OK;
            state <= ST_WAIT_INFO;
          end else if (cnt_q == cfg_limit - 1'b1) begin
            status_end      <= 1'b1;
            status_code     <= RES_TIMEOUT;
            status_followup <= 2'd0;
            state           <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT_INFO: begin
          if (rx_info_evt) begin
            if (part2_q) begin
              state <= ST_WAIT_INFO2;
            end else begin
              status_end      <= 1'b1;
              status_code     <= res_q;
              status_followup <= followup_of(res_q, r2r_q, needed_now);
              state           <= ST_IDLE;
            end
          end
        end
        ST_WAIT_INFO2: begin
          if (rx_info2_evt) begin
            status_end      <= 1'b1;
            status_code     <= res_q;
            status_followup <= followup_of(res_q, r2r_q, needed_now);
            state           <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R11
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_end |=> !status_end);

  // R8
  part2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT_INFO2 && !rx_info2_evt) |=> !status_end);

  // R9
  timeout_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_end && status_code == RES_TIMEOUT) |->
      ($past(state) == ST_WAIT_FRAME && $past(cnt_q) == $past(cfg_limit) - 1'b1));

  // R2
  none_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && desc_valid && desc_rtype == '0) |=> (state == ST_IDLE && !status_end));

  // R10
  cmd_followup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_end && r2r_q == FU_CMD) |-> (status_followup == 2'd0));

  // R1
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_ready && desc_valid && desc_rtype != '0) |=> !desc_ready);
endmodule

// File: rtl/resp_eval_ctrl.sv
module resp_eval_ctrl
  import resp_eval_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int CNT_W  = 8,
  parameter bit BSS_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              desc_valid,
  output logic              desc_ready,
  input  logic [4:0]        desc_rtype,
  input  logic [1:0]        desc_r2r,
  input  logic              desc_part2,
  input  logic              desc_bss_chk,
  input  logic [ADDR_W-1:0] desc_tx_addr,
  input  logic [ADDR_W-1:0] cfg_tbssid,
  input  logic [CNT_W-1:0]  cfg_sifs_limit,
  input  logic              rx_frame_valid,
  input  logic [2:0]        rx_class,
  input  logic [ADDR_W-1:0] rx_ra,
  input  logic              rx_info_evt,
  input  logic              rx_info2_evt,
  input  logic              rx_resp_needed,
  output logic              status_end,
  output logic [1:0]        status_code,
  output logic [1:0]        status_followup
);
  logic [TYPE_W-1:0] rtype_q;
  logic              bss_chk_q;
  logic [ADDR_W-1:0] tx_addr_q;
  logic              class_ok;
  logic              addr_needed;
  logic              addr_hit;

  resp_type_judge u_judge (
    .rtype       (rtype_q),
    .rx_class    (rx_class),
    .class_ok    (class_ok),
    .addr_needed (addr_needed)
  );

  resp_addr_match #(.ADDR_W(ADDR_W), .BSS_EN(BSS_EN)) u_match (
    .ra      (rx_ra),
    .tx_addr (tx_addr_q),
    .tbssid  (cfg_tbssid),
    .bss_chk (bss_chk_q),
    .hit     (addr_hit)
  );

  resp_eval_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_fsm (
    .clk               (clk),
    .rst_n             (rst_n),
    .desc_valid        (desc_valid),
    .desc_ready        (desc_ready),
    .desc_rtype        (desc_rtype),
    .desc_r2r          (desc_r2r),
    .desc_part2        (desc_part2),
    .desc_bss_chk      (desc_bss_chk),
    .desc_tx_addr      (desc_tx_addr),
    .cfg_limit         (cfg_sifs_limit),
    .rx_frame_valid    (rx_frame_valid),
    .frame_class_ok    (class_ok),
    .frame_addr_hit    (addr_hit),
    .frame_addr_needed (addr_needed),
    .rx_info_evt       (rx_info_evt),
    .rx_info2_evt      (rx_info2_evt),
    .rx_resp_needed    (rx_resp_needed),
    .rtype_q           (rtype_q),
    .bss_chk_q         (bss_chk_q),
    .tx_addr_q         (tx_addr_q),
    .status_end        (status_end),
    .status_code       (status_code),
    .status_followup   (status_followup)
  );

  // R3
  ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_ready && rtype_q == 5'd1 && rx_frame_valid && rx_class == CLS_CTS) |-> !class_ok);

  // R4
  ba_any_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!desc_ready && (rtype_q == 5'd2 || rtype_q == 5'd22) && rx_class == CLS_BA) |-> class_ok);
endmodule

// File: tb/resp_eval_ctrl_bench.sv
module resp_eval_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] TX_A  = 48'h0011_2233_4455;
  localparam logic [47:0] TB_A  = 48'h00AA_BBCC_DDEE;
  localparam logic [47:0] BAD_A = 48'h0099_8877_6655;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        desc_valid = 1'b0;
  logic        desc_ready;
  logic [4:0]  desc_rtype = '0;
  logic [1:0]  desc_r2r = '0;
  logic        desc_part2 = 1'b0;
  logic        desc_bss_chk = 1'b0;
  logic [47:0] desc_tx_addr = '0;
  logic [47:0] cfg_tbssid = TB_A;
  logic [7:0]  cfg_sifs_limit = 8'd20;
  logic        rx_frame_valid = 1'b0;
  logic [2:0]  rx_class = '0;
  logic [47:0] rx_ra = '0;
  logic        rx_info_evt = 1'b0;
  logic        rx_info2_evt = 1'b0;
  logic        rx_resp_needed = 1'b0;
  logic        status_end;
  logic [1:0]  status_code;
  logic [1:0]  status_followup;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  resp_eval_ctrl u_resp_eval_ctrl (
    .clk(clk), .rst_n(rst_n),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_rtype(desc_rtype), .desc_r2r(desc_r2r), .desc_part2(desc_part2),
    .desc_bss_chk(desc_bss_chk), .desc_tx_addr(desc_tx_addr),
    .cfg_tbssid(cfg_tbssid), .cfg_sifs_limit(cfg_sifs_limit),
    .rx_frame_valid(rx_frame_valid), .rx_class(rx_class), .rx_ra(rx_ra),
    .rx_info_evt(rx_info_evt), .rx_info2_evt(rx_info2_evt),
    .rx_resp_needed(rx_resp_needed),
    .status_end(status_end), .status_code(status_code),
    .status_followup(status_followup)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic send_desc(input logic [4:0] t, input logic [1:0] m, input logic p2, input logic bc);
    desc_valid = 1'b1; desc_rtype = t; desc_r2r = m; desc_part2 = p2;
    desc_bss_chk = bc; desc_tx_addr = TX_A;
    @(negedge clk);
    desc_valid = 1'b0;
  endtask

  task automatic pulse_frame(input logic [2:0] c, input logic [47:0] a, input logic need);
    rx_frame_valid = 1'b1; rx_class = c; rx_ra = a; rx_resp_needed = need;
    @(negedge clk);
    rx_frame_valid = 1'b0; rx_resp_needed = 1'b0;
  endtask

  task automatic pulse_info;
    rx_info_evt = 1'b1; @(negedge clk); rx_info_evt = 1'b0;
  endtask

  task automatic pulse_info2;
    rx_info2_evt = 1'b1; @(negedge clk); rx_info2_evt = 1'b0;
  endtask

  // One full exchange with a frame, then checks of the status pulse
  task automatic exchange(input string req, input logic [4:0] t, input logic [1:0] m,
                          input logic p2, input logic bc, input logic [2:0] c,
                          input logic [47:0] a, input logic need,
                          input int exp_code, input int exp_fu);
    send_desc(t, m, p2, bc);
    check(req, "ready low while busy", desc_ready, 0);
    @(negedge clk);
    pulse_frame(c, a, need);
    pulse_info;
    if (p2) begin
      check(req, "no status before part-2", status_end, 0);
      pulse_info2;
    end
    check(req, "status_end", status_end, 1);
    check(req, "status_code", status_code, exp_code);
    check(req, "status_followup", status_followup, exp_fu);
    @(negedge clk);
    check(req, "status pulse one cycle", status_end, 0);
    check(req, "ready after status", desc_ready, 1);
  endtask

  task automatic t_reset;
    check("R11", "reset status_end", status_end, 0);
    check("R11", "reset code", status_code, 0);
    check("R1", "reset ready", desc_ready, 1);
  endtask

  task automatic t_single_class;
    exchange("R3", 5'd1, 2'd0, 1'b0, 1'b0, 3'd0, TX_A, 1'b0, 0, 0);
    exchange("R3", 5'd1, 2'd0, 1'b0, 1'b0, 3'd2, TX_A, 1'b0, 1, 0);
    exchange("R3", 5'd6, 2'd0, 1'b0, 1'b0, 3'd2, TX_A, 1'b0, 0, 0);
    exchange("R3", 5'd4, 2'd0, 1'b0, 1'b0, 3'd4, TX_A, 1'b0, 0, 0);
    exchange("R3", 5'd4, 2'd0, 1'b0, 1'b0, 3'd0, TX_A, 1'b0, 1, 0);
  endtask

  task automatic t_ba_sizes;
    exchange("R4", 5'd2,  2'd0, 1'b0, 1'b0, 3'd1, TX_A, 1'b0, 0, 0);
    exchange("R4", 5'd3,  2'd0, 1'b0, 1'b0, 3'd1, TX_A, 1'b0, 0, 0);
    exchange("R4", 5'd21, 2'd0, 1'b0, 1'b0, 3'd1, TX_A, 1'b0, 0, 0);
    exchange("R4", 5'd22, 2'd0, 1'b0, 1'b0, 3'd1, TX_A, 1'b0, 0, 0);
    exchange("R4", 5'd22, 2'd0, 1'b0, 1'b0, 3'd0, TX_A, 1'b0, 1, 0);
  endtask

  task automatic t_either;
    exchange("R5", 5'd5, 2'd0, 1'b0, 1'b0, 3'd0, TX_A, 1'b0, 0, 0);
    exchange("R5", 5'd5, 2'd0, 1'b0, 1'b0, 3'd1, TX_A, 1'b0, 0, 0);
    exchange("R5", 5'd5, 2'd0, 1'b0, 1'b0, 3'd3, TX_A, 1'b0, 1, 0);
    exchange("R5", 5'd7, 2'd0, 1'b0, 1'b0, 3'd3, TX_A, 1'b0, 0, 0);
    exchange("R5", 5'd7, 2'd0, 1'b0, 1'b0, 3'd1, TX_A, 1'b0, 1, 0);
  endtask

  task automatic t_any;
    exchange("R6", 5'd17, 2'd0, 1'b0, 1'b0, 3'd4, TX_A,  1'b0, 0, 0);
    exchange("R6", 5'd17, 2'd0, 1'b0, 1'b0, 3'd4, BAD_A, 1'b0, 3, 0);
    exchange("R6", 5'd18, 2'd0, 1'b0, 1'b0, 3'd2, BAD_A, 1'b0, 0, 0);
    exchange("R6", 5'd9,  2'd0, 1'b0, 1'b0, 3'd3, BAD_A, 1'b0, 0, 0);
    exchange("R6", 5'd30, 2'd0, 1'b0, 1'b0, 3'd4, BAD_A, 1'b0, 0, 0);
  endtask

  task automatic t_address;
    exchange("R7", 5'd1, 2'd0, 1'b0, 1'b0, 3'd0, BAD_A, 1'b0, 3, 0);
    exchange("R7", 5'd1, 2'd0, 1'b0, 1'b0, 3'd2, BAD_A, 1'b0, 3, 0);
    exchange("R7", 5'd1, 2'd0, 1'b0, 1'b0, 3'd0, TB_A,  1'b0, 3, 0);
    exchange("R7", 5'd1, 2'd0, 1'b0, 1'b1, 3'd0, TB_A,  1'b0, 0, 0);
    exchange("R7", 5'd1, 2'd0, 1'b0, 1'b1, 3'd0, TX_A,  1'b0, 0, 0);
  endtask

  task automatic t_part2;
    exchange("R8", 5'd1, 2'd0, 1'b1, 1'b0, 3'd0, TX_A, 1'b0, 0, 0);
    send_desc(5'd1, 2'd0, 1'b1, 1'b0);
    pulse_frame(3'd0, TX_A, 1'b0);
    pulse_info2;
    check("R8", "early part-2 ignored", status_end, 0);
    pulse_info;
    check("R8", "no status after info only", status_end, 0);
    @(negedge clk);
    check("R8", "still waiting part-2", status_end, 0);
    pulse_info2;
    check("R8", "status after part-2", status_end, 1);
    check("R8", "code after part-2", status_code, 0);
    @(negedge clk);
  endtask

  task automatic t_timeout;
    int n;
    cfg_sifs_limit = 8'd5;
    send_desc(5'd1, 2'd1, 1'b0, 1'b0);
    n = 0;
    while (!status_end && n < 50) begin
      @(negedge clk);
      n++;
      pulse_info_free();
    end
    check("R9", "timeout cycle count", n, 5);
    check("R9", "timeout code", status_code, 2);
    check("R9", "timeout followup", status_followup, 0);
    @(negedge clk);
    cfg_sifs_limit = 8'd20;
    // frame on the last window cycle still counts
    cfg_sifs_limit = 8'd3;
    send_desc(5'd1, 2'd0, 1'b0, 1'b0);
    @(negedge clk); @(negedge clk);
    pulse_frame(3'd0, TX_A, 1'b0);
    check("R9", "no timeout with frame in window", status_end, 0);
    pulse_info;
    check("R9", "late-window frame status", status_end, 1);
    check("R9", "late-window frame code", status_code, 0);
    @(negedge clk);
    cfg_sifs_limit = 8'd20;
  endtask

  task automatic pulse_info_free;
  endtask

  task automatic t_none;
    send_desc(5'd0, 2'd0, 1'b0, 1'b0);
    check("R2", "ready stays high", desc_ready, 1);
    pulse_frame(3'd0, TX_A, 1'b0);
    pulse_info;
    check("R2", "no status after info", status_end, 0);
    repeat (4) @(negedge clk);
    check("R2", "still idle", desc_ready, 1);
  endtask

  task automatic t_backpressure;
    send_desc(5'd1, 2'd0, 1'b0, 1'b0);
    send_desc(5'd0, 2'd0, 1'b0, 1'b0);
    check("R1", "held while busy", desc_ready, 0);
    pulse_frame(3'd0, TX_A, 1'b0);
    pulse_info;
    check("R1", "first descriptor completes", status_end, 1);
    check("R1", "first descriptor code", status_code, 0);
    @(negedge clk);
  endtask

  task automatic t_followup;
    exchange("R10", 5'd1, 2'd1, 1'b0, 1'b0, 3'd0, TX_A, 1'b1, 0, 1);
    exchange("R10", 5'd1, 2'd2, 1'b0, 1'b0, 3'd0, TX_A, 1'b1, 0, 2);
    exchange("R10", 5'd1, 2'd2, 1'b0, 1'b0, 3'd0, TX_A, 1'b0, 0, 0);
    exchange("R10", 5'd1, 2'd3, 1'b0, 1'b0, 3'd0, TX_A, 1'b1, 0, 0);
    exchange("R10", 5'd1, 2'd1, 1'b0, 1'b0, 3'd2, TX_A, 1'b1, 1, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single_class;
    t_ba_sizes;
    t_either;
    t_any;
    t_address;
    t_part2;
    t_timeout;
    t_none;
    t_backpressure;
    t_followup;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule